// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Flags

This block receives asynchronous serial frames on a single line. An oversampling clock enable (`os_tick`) runs at 16 or 8 pulses per bit period. The line is synchronised and a falling edge starts a frame. The start bit is confirmed by a majority vote of three samples around the bit centre. Each later bit is decided by the same vote. A frame carries `DATA_W` data bits, least significant bit first. An optional ninth bit, an optional parity bit and one checked stop bit follow the data.

Each completed character is stored with its own stop-bit error flag and parity error flag. The store is a two-entry queue plus one holding slot that stands for the finished character left in the shift register. The head entry and its flags are presented at the ports. A single-cycle read strobe removes the head. An overrun flag records that a character was lost. In filter mode, frames whose ninth bit is zero are discarded, so only address frames reach the queue. A receive interrupt request is raised from the non-empty state, gated by a local enable and a global enable.

Top module: `serial_rx_unit`

## Requirements
- R1: Up to two characters are queued and a third is held complete in the shift register. All of them are delivered in arrival order, and none is lost while no overrun occurs.
- R2: A character whose stop bit is decided as 0 is delivered with `rx_fe` = 1. A character whose stop bit is decided as 1 is delivered with `rx_fe` = 0.
- R3: `cfg_par` = 2'b10 selects even parity and 2'b11 selects odd parity. With 2'b00 or 2'b01, no parity bit is in the frame and `rx_pe` is 0. `rx_pe` reflects the parity setting in force while that character was received, not the setting at read time.
- R4: `rx_dor` is set when a new start bit is confirmed while the queue is full and the holding slot is occupied. The held character is discarded and the queued characters are kept.
- R5: `rx_data`, `rx_fe` and `rx_pe` describe the head entry. A read moves the next entry's data and flags to the head. A read also clears `rx_dor`.
- R6: With `cfg_double` = 1 a bit lasts 8 `os_tick` pulses. With `cfg_double` = 0 a bit lasts 16.
- R7: `rx_avail` is 1 exactly while the queue is non-empty. A read strobe while the queue is empty has no effect.
- R8: `rx_irq` is 1 only when `irq_en`, `gie` and `rx_avail` are all 1.
- R9: With `cfg_ninth` = 1 the frame carries a ninth bit after the data bits, delivered as `rx_data[DATA_W]`. With `cfg_mpcm` = 1, frames whose ninth bit is 0 never enter the queue.
- R10: A low pulse on the idle line that is shorter than the centre sampling window is rejected as a false start, and no character results.
- R11: Data bits are received least significant bit first and are delivered unchanged in `rx_data[DATA_W-1:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling enable, one pulse per sample |
| rxd | input | 1 | Serial line, idle high |
| cfg_double | input | 1 | 1: 8 samples per bit, 0: 16 |
| cfg_par | input | 2 | Parity mode (10 even, 11 odd, else none) |
| cfg_ninth | input | 1 | Frame carries a ninth data bit |
| cfg_mpcm | input | 1 | Drop frames whose ninth bit is 0 |
| irq_en | input | 1 | Receive interrupt enable |
| gie | input | 1 | Global interrupt enable |
| rd_strobe | input | 1 | Pop the head character |
| rx_data | output | DATA_W+1 | Head character, ninth bit on top |
| rx_fe | output | 1 | Head character had a bad stop bit |
| rx_pe | output | 1 | Head character had a parity error |
| rx_dor | output | 1 | Character lost to overrun |
| rx_avail | output | 1 | Queue non-empty |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume that `os_tick` is a single-cycle enable, that the configuration inputs change only while the line is idle and no frame is in progress, and that the line holds each bit for a whole number of samples. The stimulus keeps to these assumptions. Every frame lasts an exact multiple of the tick period, and an idle gap of two bits follows each frame. Configuration is changed only after that gap. Reads are issued as one-cycle strobes away from the clock edge, and the bench never reads while a strobe is already pending.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_DATA,
      S_NINTH,
      S_PAR,
      S_STOP
   } rx_state_e;

   localparam logic [1:0] PAR_EVEN = 2'b10;
   localparam logic [1:0] PAR_ODD  = 2'b11;

   function automatic logic par_enabled(input logic [1:0] mode);
      return mode[1];
   endfunction

endpackage

// File: rtl/rxu_bitsamp.sv
module rxu_bitsamp
   import rxu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OSR_N  = 16,
   parameter int OSR_D  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   input  logic              cfg_double,
   input  logic [1:0]        cfg_par,
   input  logic              cfg_ninth,
   output logic              start_ok,
   output logic              done,
   output logic [DATA_W:0]   fr_data,
   output logic              fr_fe,
   output logic              fr_pe
);

   localparam int CNT_W = $clog2(OSR_N);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] N_LAST = CNT_W'(OSR_N - 1);
   localparam logic [CNT_W-1:0] D_LAST = CNT_W'(OSR_D - 1);
   localparam logic [CNT_W-1:0] N_VOTE = CNT_W'(OSR_N / 2 + 1);
   localparam logic [CNT_W-1:0] D_VOTE = CNT_W'(OSR_D / 2 + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   initial begin
      assert (OSR_D >= 4 && OSR_D < OSR_N) else $error("rxu_bitsamp: bad ratios");
      assert (DATA_W >= 5) else $error("rxu_bitsamp: DATA_W too small");
   end

   rx_state_e          st;
   logic [CNT_W-1:0]   cnt;
   logic [IDX_W-1:0]   bidx;
   logic [1:0]         hist;
   logic [DATA_W:0]    shreg;
   logic               par_acc;
   logic               pe_r;
   logic               fe_r;

   logic [CNT_W-1:0]   c_last;
   logic [CNT_W-1:0]   c_vote;
   logic               vote;
   logic               at_vote;
   logic               at_end;

   always_comb begin
      c_last  = cfg_double ? D_LAST : N_LAST;
      c_vote  = cfg_double ? D_VOTE : N_VOTE;
      vote    = (hist[1] & hist[0]) | (hist[1] & rxd) | (hist[0] & rxd);
      at_vote = (cnt == c_vote);
      at_end  = (cnt == c_last);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         cnt      <= '0;
         bidx     <= '0;
         hist     <= 2'b11;
         shreg    <= '0;
         par_acc  <= 1'b0;
         pe_r     <= 1'b0;
         fe_r     <= 1'b0;
         start_ok <= 1'b0;
         done     <= 1'b0;
      end else begin
         start_ok <= 1'b0;
         done     <= 1'b0;
         if (tick) begin
            hist <= {hist[0], rxd};
            cnt  <= at_end ? '0 : cnt + 1'b1;
            case (st)
               S_IDLE: begin
                  if (!rxd) begin
                     st      <= S_START;
                     cnt     <= CNT_W'(1);
                     shreg   <= '0;
                     par_acc <= 1'b0;
                     pe_r    <= 1'b0;
                  end
               end
               S_START: begin
                  if (at_vote) begin
                     if (vote) st <= S_IDLE;
                     else      start_ok <= 1'b1;
                  end
                  if (at_end) begin
                     st   <= S_DATA;
                     bidx <= '0;
                  end
               end
               S_DATA: begin
                  if (at_vote) begin
                     shreg[bidx] <= vote;
                     par_acc     <= par_acc ^ vote;
                  end
                  if (at_end) begin
                     if (bidx == LAST_IDX) begin
                        if (cfg_ninth)                 st <= S_NINTH;
                        else if (par_enabled(cfg_par)) st <= S_PAR;
                        else                           st <= S_STOP;
                     end else begin
                        bidx <= bidx + 1'b1;
                     end
                  end
               end
               S_NINTH: begin
                  if (at_vote) begin
                     shreg[DATA_W] <= vote;
                     par_acc       <= par_acc ^ vote;
                  end
                  if (at_end) st <= par_enabled(cfg_par) ? S_PAR : S_STOP;
               end
               S_PAR: begin
                  if (at_vote) pe_r <= par_acc ^ vote ^ (cfg_par == PAR_ODD);
                  if (at_end)  st <= S_STOP;
               end
               S_STOP: begin
                  if (at_vote) begin
                     fe_r <= ~vote;
                     done <= 1'b1;
                     st   <= S_IDLE;
                  end
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   assign fr_data = shreg;
   assign fr_fe   = fe_r;
   assign fr_pe   = pe_r;

   // R10: a frame only begins from a low line sample
   p_start_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_START && $past(st) == S_IDLE) |-> !$past(rxd));

   // R2: a completed frame is reported only out of the stop-bit state
   p_done_from_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(st) == S_STOP));

endmodule

// File: rtl/rxu_fifo.sv
module rxu_fifo #(
   parameter int W     = 11,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] P_LAST = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] C_FULL = CNT_W'(DEPTH);

   initial begin
      assert (DEPTH >= 2) else $error("rxu_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic [CNT_W-1:0] cnt;
   logic             do_pop, do_push;

   assign empty   = (cnt == '0);
   assign full    = (cnt == C_FULL);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= (wp == P_LAST) ? '0 : wp + 1'b1;
         if (do_pop)  rp <= (rp == P_LAST) ? '0 : rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R1: the producer never pushes into a full queue without a pop
   p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop));

   // R7: a pop request on an empty queue leaves it empty
   p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> empty);

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
   import rxu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int BUF_DEPTH   = 2,
   parameter int SYNC_STAGES = 2,
   parameter int OSR_N       = 16,
   parameter int OSR_D       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rxd,
   input  logic              cfg_double,
   input  logic [1:0]        cfg_par,
   input  logic              cfg_ninth,
   input  logic              cfg_mpcm,
   input  logic              irq_en,
   input  logic              gie,
   input  logic              rd_strobe,
   output logic [DATA_W:0]   rx_data,
   output logic              rx_fe,
   output logic              rx_pe,
   output logic              rx_dor,
   output logic              rx_avail,
   output logic              rx_irq
);

   localparam int EW = DATA_W + 3;

   logic rxd_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rxd_s = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sr <= '1;
            end else begin
               sr[0] <= rxd;
               for (int i = 1; i < SYNC_STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign rxd_s = sr[SYNC_STAGES-1];
      end
   endgenerate

   logic            start_ok, fr_done, fr_fe, fr_pe;
   logic [DATA_W:0] fr_data;

   rxu_bitsamp #(.DATA_W(DATA_W), .OSR_N(OSR_N), .OSR_D(OSR_D)) u_samp (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (os_tick),
      .rxd        (rxd_s),
      .cfg_double (cfg_double),
      .cfg_par    (cfg_par),
      .cfg_ninth  (cfg_ninth),
      .start_ok   (start_ok),
      .done       (fr_done),
      .fr_data    (fr_data),
      .fr_fe      (fr_fe),
      .fr_pe      (fr_pe)
   );

   logic          q_push, q_empty, q_full;
   logic [EW-1:0] q_din, q_dout, fr_ent, pend_q;
   logic          pend_v, dor_q;
   logic          do_pop, can_take, fr_keep, ovr_evt;

   assign fr_ent   = {fr_data, fr_fe, fr_pe};
   assign do_pop   = rd_strobe && !q_empty;
   assign can_take = !q_full || do_pop;
   assign fr_keep  = fr_done && !(cfg_mpcm && !fr_data[DATA_W]);
   assign ovr_evt  = start_ok && pend_v && q_full && !do_pop;

   always_comb begin
      q_push = 1'b0;
      q_din  = fr_ent;
      if (pend_v && can_take) begin
         q_push = 1'b1;
         q_din  = pend_q;
      end else if (fr_keep && can_take) begin
         q_push = 1'b1;
      end
   end

   rxu_fifo #(.W(EW), .DEPTH(BUF_DEPTH)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push),
      .din   (q_din),
      .pop   (rd_strobe),
      .dout  (q_dout),
      .empty (q_empty),
      .full  (q_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v <= 1'b0;
         pend_q <= '0;
         dor_q  <= 1'b0;
      end else begin
         if (ovr_evt)                    pend_v <= 1'b0;
         else if (pend_v && can_take)    pend_v <= 1'b0;
         else if (fr_keep && !can_take) begin
            pend_v <= 1'b1;
            pend_q <= fr_ent;
         end
         if (ovr_evt)     dor_q <= 1'b1;
         else if (do_pop) dor_q <= 1'b0;
      end
   end

   assign rx_data  = q_dout[EW-1:2];
   assign rx_fe    = q_dout[1];
   assign rx_pe    = q_dout[0];
   assign rx_dor   = dor_q;
   assign rx_avail = !q_empty;
   assign rx_irq   = irq_en & gie & !q_empty;

   // R9: a non-address frame in filter mode never reaches the queue
   p_filter_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_done && cfg_mpcm && !fr_data[DATA_W]) |-> !q_push);

   // R1: the holding slot and a fresh frame never compete for the queue
   p_single_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(pend_v && fr_done));

   // R5: a read with no simultaneous overrun clears the overrun flag
   p_dor_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (do_pop && !ovr_evt) |=> !rx_dor);

   // R7: data stays available until it is read
   p_avail_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_avail && !rd_strobe) |=> rx_avail);

endmodule

// File: tb/tb_serial_rx_unit.sv
module tb_serial_rx_unit;

   localparam int DW   = 8;
   localparam int TDIV = 2;

   typedef struct packed {
      logic [DW:0] d;
      logic        fe;
      logic        pe;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          os_tick = 1'b0;
   logic          rxd = 1'b1;
   logic          cfg_double = 1'b0;
   logic [1:0]    cfg_par = 2'b00;
   logic          cfg_ninth = 1'b0;
   logic          cfg_mpcm = 1'b0;
   logic          irq_en = 1'b0;
   logic          gie = 1'b0;
   logic          rd_strobe = 1'b0;
   logic [DW:0]   rx_data;
   logic          rx_fe, rx_pe, rx_dor, rx_avail, rx_irq;

   int   nchk = 0;
   int   nfail = 0;
   int   tdiv_cnt = 0;
   bit   auto_rd = 1'b0;
   int   reads_req = 0;
   int   reads_done = 0;
   exp_t q[$];

   always #5 clk = ~clk;

   serial_rx_unit #(.DATA_W(DW)) dut (
      .clk (clk), .rst_n (rst_n), .os_tick (os_tick), .rxd (rxd),
      .cfg_double (cfg_double), .cfg_par (cfg_par), .cfg_ninth (cfg_ninth),
      .cfg_mpcm (cfg_mpcm), .irq_en (irq_en), .gie (gie),
      .rd_strobe (rd_strobe), .rx_data (rx_data), .rx_fe (rx_fe),
      .rx_pe (rx_pe), .rx_dor (rx_dor), .rx_avail (rx_avail), .rx_irq (rx_irq)
   );

   always @(negedge clk) begin
      tdiv_cnt = (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
      os_tick  = (tdiv_cnt == 0);
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever the design presents a character
   always @(negedge clk) begin
      if (rd_strobe) begin
         rd_strobe = 1'b0;
         if (!auto_rd) reads_done++;
      end else if (auto_rd ? rx_avail : (reads_done < reads_req)) begin
         if (rx_avail) begin
            exp_t e;
            if (q.size() == 0) begin
               nchk++; nfail++;
               $display("FAIL R1 unexpected character act=%0h exp=none", rx_data);
            end else begin
               e = q.pop_front();
               check("R1/R11 data", 32'(rx_data), 32'(e.d));
               check("R2 stop flag", 32'(rx_fe), 32'(e.fe));
               check("R3 parity flag", 32'(rx_pe), 32'(e.pe));
            end
         end
         rd_strobe = 1'b1;
      end
   end

   task automatic put_bit(input logic v);
      int bc;
      bc = (cfg_double ? 8 : 16) * TDIV;
      rxd = v;
      repeat (bc) @(negedge clk);
   endtask

   task automatic send(input logic [DW:0] d, input bit bad_stop, input bit bad_par, input bit store);
      logic p;
      logic pen;
      exp_t e;
      pen = cfg_par[1];
      p = ^d[DW-1:0] ^ (cfg_ninth & d[DW]) ^ (cfg_par == 2'b11) ^ bad_par;
      if (store) begin
         e.d  = {cfg_ninth & d[DW], d[DW-1:0]};
         e.fe = bad_stop;
         e.pe = pen & bad_par;
         q.push_back(e);
      end
      put_bit(1'b0);
      for (int i = 0; i < DW; i++) put_bit(d[i]);
      if (cfg_ninth) put_bit(d[DW]);
      if (pen) put_bit(p);
      put_bit(!bad_stop);
      put_bit(1'b1);
      put_bit(1'b1);
   endtask

   task automatic read_one();
      reads_req++;
      while (reads_done < reads_req) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic drain();
      for (int i = 0; i < 200 && (q.size() != 0 || rx_avail); i++) @(negedge clk);
      repeat (4) @(negedge clk);
      check("R1 scoreboard empty", 32'(q.size()), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      check("R7 avail in reset", 32'(rx_avail), 32'd0);
      check("R4 overrun in reset", 32'(rx_dor), 32'd0);
      check("R8 irq in reset", 32'(rx_irq), 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R11 R6: plain frames at 16 samples per bit
      auto_rd = 1'b1;
      send(9'h0A5, 0, 0, 1);
      send(9'h03C, 0, 0, 1);
      send(9'h000, 0, 0, 1);
      send(9'h0FF, 0, 0, 1);
      drain();

      // R2: bad stop bit, then a clean frame
      send(9'h05A, 1, 0, 1);
      send(9'h081, 0, 0, 1);
      drain();

      // R3: even then odd parity, good and bad
      cfg_par = 2'b10;
      send(9'h037, 0, 0, 1);
      send(9'h037, 0, 1, 1);
      cfg_par = 2'b11;
      send(9'h012, 0, 0, 1);
      send(9'h012, 0, 1, 1);
      drain();

      // R6: double speed, 8 samples per bit
      cfg_par = 2'b00;
      cfg_double = 1'b1;
      send(9'h0C3, 0, 0, 1);
      send(9'h07E, 0, 0, 1);
      drain();
      cfg_double = 1'b0;

      // R3: flag follows reception-time setting
      auto_rd = 1'b0;
      cfg_par = 2'b10;
      send(9'h055, 0, 1, 1);
      cfg_par = 2'b00;
      read_one();

      // R8: interrupt gating
      send(9'h044, 0, 0, 1);
      check("R7 avail after frame", 32'(rx_avail), 32'd1);
      irq_en = 1'b1; gie = 1'b0; @(negedge clk);
      check("R8 irq without gie", 32'(rx_irq), 32'd0);
      gie = 1'b1; @(negedge clk);
      check("R8 irq all enabled", 32'(rx_irq), 32'd1);
      irq_en = 1'b0; @(negedge clk);
      check("R8 irq without enable", 32'(rx_irq), 32'd0);
      irq_en = 1'b1;
      read_one();
      check("R7 avail after read", 32'(rx_avail), 32'd0);
      check("R8 irq when empty", 32'(rx_irq), 32'd0);

      // R7: strobe on empty queue has no effect
      read_one();
      check("R7 avail after empty read", 32'(rx_avail), 32'd0);
      send(9'h0B4, 0, 0, 1);
      read_one();
      check("R7 empty after single read", 32'(rx_avail), 32'd0);

      // R1: three characters, no overrun
      send(9'h011, 0, 0, 1);
      send(9'h022, 0, 0, 1);
      send(9'h033, 0, 0, 1);
      check("R1 no overrun with three", 32'(rx_dor), 32'd0);
      read_one(); read_one(); read_one();
      check("R1 all three delivered", 32'(rx_avail), 32'd0);

      // R4 R5: overrun drops the held character
      send(9'h0A1, 0, 0, 1);
      send(9'h0B2, 0, 0, 1);
      send(9'h0C3, 0, 0, 0);
      check("R4 no overrun before fourth", 32'(rx_dor), 32'd0);
      send(9'h0D4, 0, 0, 1);
      check("R4 overrun set", 32'(rx_dor), 32'd1);
      check("R4 head kept", 32'(rx_data), 32'h0A1);
      read_one();
      check("R5 overrun cleared by read", 32'(rx_dor), 32'd0);
      check("R5 next head", 32'(rx_data), 32'h0B2);
      read_one(); read_one();
      check("R4 queue empty after", 32'(rx_avail), 32'd0);

      // R9: address filter
      cfg_ninth = 1'b1;
      cfg_mpcm = 1'b1;
      send(9'h055, 0, 0, 0);
      check("R9 data frame dropped", 32'(rx_avail), 32'd0);
      send(9'h10A, 0, 0, 1);
      check("R9 address frame kept", 32'(rx_avail), 32'd1);
      read_one();
      cfg_mpcm = 1'b0;
      send(9'h066, 0, 0, 1);
      read_one();
      cfg_ninth = 1'b0;

      // R10: short low glitch
      rxd = 1'b0;
      repeat (3 * TDIV) @(negedge clk);
      rxd = 1'b1;
      repeat (64 * TDIV) @(negedge clk);
      check("R10 glitch rejected", 32'(rx_avail), 32'd0);
      send(9'h099, 0, 0, 1);
      read_one();
      drain();

      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule